// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous system bus and an asynchronous 128K x 8 static RAM. A requester offers one read or one write at a time on a valid/ready handshake. The controller captures the address and write data, then produces registered strobe sequences on the RAM pins. Those pins are a pair of chip selects of opposite polarity (one active-low, one active-high), an active-low write enable, an active-low output enable, a 17-bit address, and an 8-bit data bus whose driver has its own enable. Read data comes back with a single-cycle response pulse.

Every minimum time is given in nanoseconds together with the clock period. It is turned into a whole number of clock cycles when the design is elaborated, and never fewer than one. A standby input parks the RAM deselected for low-power retention. When standby is released, a full read cycle time must pass before the next request is accepted.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset the RAM is deselected (active-low select at 1, active-high select at 0). Write enable and output enable are both 1 and the data driver is off. The response pulse is 0, and the request ready is 1 while standby is not requested.
- R2: The RAM is selected, with the active-low select at 0 and the active-high select at 1 together, only during the read window and the write-pulse window. At all other times both selects are in their deselected state.
- R3: A read holds output enable at 0, write enable at 1 and the chip selected for exactly ceil(55 ns / clock period) cycles, which is 6 cycles at 10 ns. The data bus is sampled at the clock edge that closes this window.
- R4: Read data appears on the response data output with the response-valid pulse, which lasts exactly one cycle. The pulse is first seen 7 cycles after the accepting edge at default settings.
- R5: A write holds write enable at 0 with the chip selected for ceil(max(40, 45, 25) ns / period) cycles, which is 5 cycles at 10 ns. Output enable stays at 1 for the whole write, and the captured data is driven from the same edge on which write enable falls.
- R6: After write enable rises, the address and data stay driven for max(1, ceil(55 ns / period) - pulse cycles) cycles before the driver is released.
- R7: The data driver is enabled only in the write-pulse and write-recovery states, and never while output enable is 0.
- R8: Each read is followed by one idle cycle in which ready is 0, so a following write never overlaps a read.
- R9: A request is accepted only on an edge where both valid and ready are 1. Address, direction and write data are captured on that edge.
- R10: While standby is requested and the controller is idle or in standby, the RAM stays deselected, ready is 0 and no strobe moves.
- R11: After standby is released, ready stays 0 for ceil(55 ns / period) cycles (6 at default), plus the cycle of the release edge, before a request can be accepted.
- R12: When standby and a request arrive together while idle, standby wins. The request stays pending and is served after recovery with its stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Request address |
| reqWdata | input | 8 | Write data |
| rspValid | output | 1 | One-cycle read response pulse |
| rspRdata | output | 8 | Read data |
| sleepReq | input | 1 | Standby/retention request |
| memAddr | output | 17 | RAM address |
| memSelN | output | 1 | RAM active-low chip select |
| memSel | output | 1 | RAM active-high chip select |
| memWeN | output | 1 | RAM write enable, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memDqOut | output | 8 | Data toward the RAM |
| memDqOe | output | 1 | Enable for the data-bus driver |
| memDqIn | input | 8 | Data from the RAM |

## Verification
The hardest case to reach is a request that is already pending when standby is raised, followed by the wake-up wait. Only with both present does it show whether the controller obeys the priority and then counts the full recovery before it serves the stored request. The bench sets valid and standby on the same edge, watches the pins stay quiet, and releases standby. It then counts the cycles until ready returns and confirms the read returns the value written before standby. The RAM model gives valid data only once the output enable has been low for the full access count, so a read window that is too short returns a wrong value. Random mixes of reads and writes to random addresses cover back-to-back read/write turnarounds.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef struct packed {
    logic sel;
    logic we;
    logic oe;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_TURN, ST_WRITE, ST_WREC, ST_SLEEP, ST_WAKE
  } ctrl_state_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 6,
  parameter int WR_CYC   = 5,
  parameter int WREC_CYC = 1,
  parameter int REC_CYC  = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    sleepReq,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int MAXC  = maxOf(maxOf(RD_CYC, WR_CYC), maxOf(WREC_CYC, REC_CYC));
  localparam int CNT_W = $clog2(MAXC + 1);

  ctrl_state_t state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;

  assign reqReady = (state == ST_IDLE) && !sleepReq;

  always_comb begin
    nextState   = state;
    nextCnt     = cnt;
    stb         = '0;
    case (state)
      ST_IDLE: begin
        if (sleepReq) begin
          nextState = ST_SLEEP;
        end else if (reqValid) begin
          stb.load = 1'b1;
          if (reqWrite) begin
            nextState = ST_WRITE;
            nextCnt   = CNT_W'(WR_CYC - 1);
          end else begin
            nextState = ST_READ;
            nextCnt   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          nextState   = ST_TURN;
          stb.capture = 1'b1;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_TURN: nextState = ST_IDLE;
      ST_WRITE: begin
        if (cnt == '0) begin
          nextState = ST_WREC;
          nextCnt   = CNT_W'(WREC_CYC - 1);
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_WREC: begin
        if (cnt == '0) nextState = ST_IDLE;
        else           nextCnt   = cnt - 1'b1;
      end
      ST_SLEEP: begin
        if (!sleepReq) begin
          nextState = ST_WAKE;
          nextCnt   = CNT_W'(REC_CYC - 1);
        end
      end
      ST_WAKE: begin
        if (cnt == '0) nextState = ST_IDLE;
        else           nextCnt   = cnt - 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
    stb.sel   = (nextState == ST_READ) || (nextState == ST_WRITE);
    stb.we    = (nextState == ST_WRITE);
    stb.oe    = (nextState == ST_READ);
    stb.drive = (nextState == ST_WRITE) || (nextState == ST_WREC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  AST_TURN_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TURN) |-> ($past(state) == ST_READ)); // R8
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && sleepReq) |-> (!stb.sel && !stb.load)); // R10
  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE && $past(state) != ST_WAKE) |-> ($past(state) == ST_SLEEP)); // R11

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSel,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      memSelN  <= 1'b1;
      memSel   <= 1'b0;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memDqOe  <= 1'b0;
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      if (stb.load) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
      end
      memSelN  <= !stb.sel;
      memSel   <= stb.sel;
      memWeN   <= !stb.we;
      memOeN   <= !stb.oe;
      memDqOe  <= stb.drive;
      rspValid <= stb.capture;
      if (stb.capture) rspRdata <= memDqIn;
    end
  end

  AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rstN)
    !(memDqOe && !memOeN)); // R7
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN); // R5
  AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memSelN && memSel && memDqOe)); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R4
  AST_ADDR_HELD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && $past(memDqOe)) |-> $stable(memAddr)); // R6

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_READ_NS     = 55,
  parameter int T_WPULSE_NS   = 40,
  parameter int T_SELEND_NS   = 45,
  parameter int T_DSETUP_NS   = 25,
  parameter int T_WCYCLE_NS   = 55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  input  logic              sleepReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSel,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RD_CYC   = nsToCycles(T_READ_NS, CLK_PERIOD_NS);
  localparam int WR_CYC   = nsToCycles(maxOf(maxOf(T_WPULSE_NS, T_SELEND_NS), T_DSETUP_NS), CLK_PERIOD_NS);
  localparam int WC_CYC   = nsToCycles(T_WCYCLE_NS, CLK_PERIOD_NS);
  localparam int WREC_CYC = maxOf(1, WC_CYC - WR_CYC);
  localparam int REC_CYC  = nsToCycles(T_READ_NS, CLK_PERIOD_NS);

  strobe_t stb;

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .WREC_CYC(WREC_CYC), .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .sleepReq(sleepReq), .reqReady(reqReady), .stb(stb)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDqIn(memDqIn), .rspValid(rspValid), .rspRdata(rspRdata),
    .memAddr(memAddr), .memSelN(memSelN), .memSel(memSel), .memWeN(memWeN),
    .memOeN(memOeN), .memDqOut(memDqOut), .memDqOe(memDqOe)
  );

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

  localparam int RD_NEED  = 6;   // ceil(55/10)
  localparam int WR_NEED  = 5;   // ceil(45/10)
  localparam int REC_NEED = 6;   // ceil(55/10)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, sleepReq = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic reqReady, rspValid, memSelN, memSel, memWeN, memOeN, memDqOe;
  logic [7:0] rspRdata, memDqOut, memDqIn;
  logic [16:0] memAddr;

  int tests = 0, fails = 0;
  logic [7:0] cells [int];
  logic [7:0] refMem [int];
  int rdCnt = 0, weLow = 0, driveOnOe = 0, selBad = 0;
  logic prevWeN = 1'b1;

  always #5 clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .sleepReq(sleepReq),
    .memAddr(memAddr), .memSelN(memSelN), .memSel(memSel), .memWeN(memWeN),
    .memOeN(memOeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  function automatic logic [7:0] cellAt(input logic [16:0] a);
    return cells.exists(int'(a)) ? cells[int'(a)] : 8'h5A;
  endfunction

  function automatic logic [7:0] refAt(input logic [16:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : 8'h5A;
  endfunction

  // RAM pin model: data valid only after the full access time
  wire readAct = !memSelN && memSel && !memOeN && memWeN;
  always @(posedge clk) rdCnt <= readAct ? rdCnt + 1 : 0;
  always_comb memDqIn = (readAct && rdCnt >= RD_NEED - 1) ? cellAt(memAddr) : 8'hEE;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pin monitor
  always @(negedge clk) if (rstN) begin
    if (memDqOe && !memOeN) driveOnOe++;
    if (memSelN == memSel) selBad++;
    if (!(readAct || !memWeN) && !memSelN) selBad++;
    if (!memWeN) weLow++;
    if (memWeN && !prevWeN) begin
      check(weLow == WR_NEED, "R5 write pulse width", weLow, WR_NEED);
      check(memDqOe == 1'b1, "R6 data held after write", memDqOe, 1);
      cells[int'(memAddr)] = memDqOut;
      weLow = 0;
    end
    prevWeN = memWeN;
  end

  task automatic doWrite(input logic [16:0] a, input logic [7:0] d);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    refMem[int'(a)] = d;
    while (!reqReady) @(negedge clk);
  endtask

  task automatic doRead(input logic [16:0] a);
    int lat;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 50) begin @(negedge clk); lat++; end
    check(lat == RD_NEED + 1, "R3 read window length", lat, RD_NEED + 1);
    check(rspRdata == refAt(a), "R4 read data", rspRdata, refAt(a));
    check(reqReady == 1'b0, "R8 idle after read", reqReady, 0);
    @(negedge clk);
    check(rspValid == 1'b0, "R4 one-cycle pulse", rspValid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    logic [16:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(memSelN && !memSel, "R1 deselected", {memSelN, memSel}, 2'b10);
    check(memWeN && memOeN && !memDqOe, "R1 strobes idle", {memWeN, memOeN, memDqOe}, 3'b110);
    check(!rspValid && reqReady, "R1 handshake", {rspValid, reqReady}, 2'b01);

    // Directed: address extremes, write then read back
    doWrite(17'h00000, 8'hA5);
    doWrite(17'h1FFFF, 8'h3C);
    doRead(17'h00000);
    doRead(17'h1FFFF);
    doRead(17'h12345);            // never written
    // read immediately followed by write (R8 turnaround)
    doRead(17'h1FFFF);
    doWrite(17'h1FFFF, 8'hC3);
    doRead(17'h1FFFF);

    // Random mix (R9 capture)
    for (int i = 0; i < 300; i++) begin
      a = (i % 4 == 0) ? 17'(($urandom % 8)) : 17'($urandom);
      if ($urandom % 2) doWrite(a, 8'($urandom));
      else              doRead(a);
    end

    // R10/R12: standby and request together
    doWrite(17'h0ABCD, 8'h77);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 17'h0ABCD; sleepReq = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check(!reqReady && memSelN && !memSel && memOeN && memWeN,
            "R10 standby quiet", {reqReady, memSelN, memSel, memOeN, memWeN}, 5'b01011);
    end
    check(!rspValid, "R12 no read during standby", rspValid, 0);
    // R11 recovery
    sleepReq = 1'b0;
    k = 0;
    while (!reqReady && k < 50) begin @(negedge clk); k++; end
    check(k == REC_NEED + 1, "R11 wake recovery", k, REC_NEED + 1);
    @(negedge clk);
    reqValid = 1'b0;
    k = 1;
    while (!rspValid && k < 50) begin @(negedge clk); k++; end
    check(rspRdata == 8'h77, "R12 pending read served", rspRdata, 8'h77);
    @(negedge clk);

    check(driveOnOe == 0, "R7 driver with output enable", driveOnOe, 0);
    check(selBad == 0, "R2 select pair", selBad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule